// File: doc/BRIEF.md
# Round-Gated Cipher State Fault Injector

This block sits between the key-addition output of an iterative 128-bit block cipher and the input of its next round. The cipher is assumed to finish one round per clock, so one encryption spans 11 cycles: the initial key addition (round 0) and rounds 1 to 10. The block tracks the round index from a start strobe. When the lowest `TRIG_W` bits of the incoming state are all ones during the fault round, it flips one bit of the state handed onward.

The trigger is a wide AND built as a tree of small leaf ANDs. It evaluates every cycle whether or not it fires, so its switching activity is present in normal operation. The payload is a single XOR. The block serves as a parameterised element in side-channel detection experiments, where the trigger width sets the size of the added logic.

Top module: `round_fault_monitor`

## Requirements
- R1: After reset and before any start strobe, the round tracker is idle at round 10, so no fault is injected and `active_o` stays 0 whatever the state input.
- R2: The cycle in which `start_i` is high is round 0. Each later cycle advances the round by one until round 10, where it holds until the next start.
- R3: A fault is injected in a cycle exactly when the current round is 8 (`FAULT_ROUND`) and bits `[TRIG_W-1:0]` of `ark_state_i` are all ones.
- R4: When a fault is injected, `state_o` equals `ark_state_i` with bit 127 (`FAULT_BIT`) inverted. Bits 126:0 always equal the input in the same cycle, whether or not a fault is injected.
- R5: If any bit of `[TRIG_W-1:0]` is 0, or the round is not 8, then `state_o` equals `ark_state_i` unchanged.
- R6: `active_o` is registered. It is 1 in the cycle after a fault and is never high for two cycles in a row.
- R7: A start strobe during a run restarts the count at round 0, and the fault round is then counted from the new strobe.
- R8: While `rst_ni` is low, `state_o` equals `ark_state_i`, `active_o` is 0, and the round tracker returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Marks the current cycle as round 0 |
| ark_state_i | input | 128 | State after key addition |
| state_o | output | 128 | State passed to the next round, possibly with one bit flipped |
| active_o | output | 1 | High for one cycle after a fault injection |

## Verification
The bench tries several input patterns:
- State words with every trigger bit set on every cycle of a full run. These should show a flip only in round 8, and none once the count is saturated or idle.
- The same runs with a single trigger bit cleared, including the top trigger bit. These separate a full-width AND from a partial one.
- Random states, where the trigger almost never matches, and inputs with bit 127 already set, so the flip is seen in both directions.
- A restart strobe in the middle of a run, strobes on back-to-back cycles, and reset asserted in the fault round. These separate the round counting from the trigger match.

// File: rtl/ftm_pkg.sv
package ftm_pkg;
  localparam int unsigned STATE_W     = 128;
  localparam int unsigned LAST_ROUND  = 10;
  localparam int unsigned FAULT_ROUND = 8;
  localparam int unsigned RND_W       = $clog2(LAST_ROUND + 1);
  typedef logic [RND_W-1:0] rnd_t;
endpackage

// File: rtl/ftm_round_tracker.sv
module ftm_round_tracker
  import ftm_pkg::*;
#(
  parameter int unsigned LAST = LAST_ROUND
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output rnd_t round_o
);
  rnd_t cnt_q, cur, nxt;

  always_comb begin
    cur = start_i ? '0 : cnt_q;
    nxt = (cur < rnd_t'(LAST)) ? cur + rnd_t'(1) : rnd_t'(LAST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= rnd_t'(LAST);
    else         cnt_q <= nxt;
  end

  assign round_o = cur;

  assert_round_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= rnd_t'(LAST));
  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == rnd_t'(1)));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && cnt_q == rnd_t'(LAST)) |=> (cnt_q == rnd_t'(LAST)));
endmodule

// File: rtl/ftm_and_tree.sv
module ftm_and_tree #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned LEAF_W = 8
) (
  input  logic [WIDTH-1:0] bits_i,
  output logic             hit_o
);
  localparam int unsigned NUM_LEAF = (WIDTH + LEAF_W - 1) / LEAF_W;
  localparam int unsigned PAD_W    = NUM_LEAF * LEAF_W;

  logic [PAD_W-1:0]    padded;
  logic [NUM_LEAF-1:0] leaf;

  always_comb begin
    padded = '1;
    padded[WIDTH-1:0] = bits_i;
  end

  for (genvar g = 0; g < NUM_LEAF; g++) begin : g_leaf
    assign leaf[g] = &padded[g*LEAF_W +: LEAF_W];
  end

  assign hit_o = &leaf;
endmodule

// File: rtl/ftm_xor_payload.sv
module ftm_xor_payload #(
  parameter int unsigned WIDTH = 128,
  parameter int unsigned BIT   = 127
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic             fire_i,
  output logic [WIDTH-1:0] state_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (b == BIT) begin : g_flip
      assign state_o[b] = state_i[b] ^ fire_i;
    end else begin : g_pass
      assign state_o[b] = state_i[b];
    end
  end
endmodule

// File: rtl/round_fault_monitor.sv
module round_fault_monitor
  import ftm_pkg::*;
#(
  parameter int unsigned TRIG_W    = 32,
  parameter int unsigned LEAF_W    = 8,
  parameter int unsigned FAULT_RND = FAULT_ROUND,
  parameter int unsigned FAULT_BIT = STATE_W - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [STATE_W-1:0] ark_state_i,
  output logic [STATE_W-1:0] state_o,
  output logic               active_o
);
  rnd_t round;
  logic trig_hit, round_hit, fire, active_q;

  ftm_round_tracker #(.LAST(LAST_ROUND)) u_track (
    .clk_i, .rst_ni, .start_i, .round_o(round)
  );

  ftm_and_tree #(.WIDTH(TRIG_W), .LEAF_W(LEAF_W)) u_trig (
    .bits_i(ark_state_i[TRIG_W-1:0]), .hit_o(trig_hit)
  );

  assign round_hit = (round == rnd_t'(FAULT_RND));
  assign fire      = rst_ni & round_hit & trig_hit;

  ftm_xor_payload #(.WIDTH(STATE_W), .BIT(FAULT_BIT)) u_pay (
    .state_i(ark_state_i), .fire_i(fire), .state_o(state_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= fire;
  end
  assign active_o = active_q;

  assert_flip_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o[FAULT_BIT] != ark_state_i[FAULT_BIT]) |=> active_o);
  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |=> !active_o);
  assert_idle_no_fault_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (round == rnd_t'(LAST_ROUND)) |-> (state_o == ark_state_i));
  assert_reset_pass_R8: assert property (@(posedge clk_i)
    !rst_ni |-> (state_o == ark_state_i && !active_o));
  assert_trigger_needed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_hit |-> (state_o == ark_state_i));
endmodule

// File: tb/round_fault_monitor_tb_top.sv
module round_fault_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 32;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0;
  logic [127:0] ark = '0;
  logic [127:0] state;
  logic act;

  int n_cmp = 0, n_bad = 0;
  int mdl_rnd = 10;
  bit exp_act = 1'b0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  round_fault_monitor #(.TRIG_W(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .ark_state_i(ark), .state_o(state), .active_o(act)
  );

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // One cycle: check registered flag, drive, check combinational output, advance model.
  task automatic step(input bit st, input logic [127:0] d);
    int cur;
    bit fire;
    logic [127:0] e;
    @(negedge clk);
    chk("R6", {127'b0, act}, {127'b0, exp_act});
    start = st; ark = d;
    #1;
    cur  = st ? 0 : mdl_rnd;
    fire = rst_ni && cur == 8 && (&d[TW-1:0]);
    e = d;
    if (fire) e[127] = ~e[127];
    chk(!rst_ni ? "R8" : (fire ? "R3" : phase), state, e);
    chk("R4", {1'b0, state[126:0]}, {1'b0, d[126:0]});
    if (!rst_ni) begin mdl_rnd = 10; exp_act = 0; end
    else begin mdl_rnd = (cur < 10) ? cur + 1 : 10; exp_act = fire; end
  endtask

  function automatic logic [127:0] ones_low(input logic [127:0] d);
    logic [127:0] r = d;
    r[TW-1:0] = '1;
    return r;
  endfunction

  initial begin
    fork
      begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    join_none

    // R8: reset held, trigger bits set
    phase = "R8";
    for (int i = 0; i < 3; i++) step(0, ones_low(rnd128()));
    for (int i = 0; i < 3; i++) step(i == 1, ones_low(rnd128()));
    @(negedge clk); rst_ni = 1'b1;

    // R1: idle after reset, no start
    phase = "R1";
    for (int i = 0; i < 12; i++) step(0, ones_low(rnd128()));

    // R2/R3: full runs with trigger set every cycle, then saturation
    phase = "R2";
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 16; i++) begin
        logic [127:0] d = ones_low(rnd128());
        if (r == 1) d[127] = 1'b1;
        if (r == 2) d[127] = 1'b0;
        step(i == 0, d);
      end
    end

    // R5: one trigger bit cleared in round 8
    phase = "R5";
    for (int k = 0; k < TW; k += 7) begin
      for (int i = 0; i < 12; i++) begin
        logic [127:0] d = ones_low(rnd128());
        if (i == 8) d[k] = 1'b0;
        step(i == 0, d);
      end
    end
    for (int i = 0; i < 12; i++) begin
      logic [127:0] d = ones_low(rnd128());
      if (i == 8) d[TW-1] = 1'b0;
      step(i == 0, d);
    end
    // random state words
    for (int i = 0; i < 60; i++) step(i % 11 == 0, rnd128());

    // R7: restart mid-run, then back-to-back strobes
    phase = "R7";
    for (int i = 0; i < 20; i++) step(i == 0 || i == 5, ones_low(rnd128()));
    for (int i = 0; i < 10; i++) step(1, ones_low(rnd128()));
    for (int i = 0; i < 12; i++) step(0, ones_low(rnd128()));

    // R8: reset asserted in the fault round
    phase = "R8";
    for (int i = 0; i < 8; i++) step(i == 0, ones_low(rnd128()));
    @(negedge clk); rst_ni = 1'b0;
    mdl_rnd = 10; exp_act = 0;
    step(0, ones_low(rnd128()));
    step(0, ones_low(rnd128()));
    @(negedge clk); rst_ni = 1'b1;
    phase = "R1";
    for (int i = 0; i < 12; i++) step(0, ones_low(rnd128()));
    phase = "R2";
    for (int i = 0; i < 12; i++) step(i == 0, ones_low(rnd128()));
    step(0, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule